// File: doc/BRIEF.md
# PHY Reset Sequencer with Strap Capture

This block turns two reset requests into one internal reset for a 10/100 Ethernet physical-layer core. One request comes from an external reset pin and the other from a self-clearing bit in control register 0. The pin is first synchronised into the clock domain. It only counts as a reset once it has stayed high for a minimum time, so short glitches are dropped. Once the pin has been released, the internal reset stays asserted for a further settling interval. On the last cycle of that interval the configuration strap inputs are captured. The same settling-and-capture tail serves both reset sources, and it also runs once after the power-on reset input is released.

A software reset is started by writing register 0 with its top bit set. That bit reads back as 1 for as long as the reset is in progress. A busy flag then stays up for a hold-off window, during which management software should not touch the core. Every reset returns the remaining control bits to their defaults. While the reset is in progress the speed indicator pins show 10 Mb/s. All durations are given in time units and converted to clock cycles from a clock-frequency parameter.

Top module: `phy_rst_ctrl`

## Requirements
- R1: The reset pin passes through SYNC_STAGES flops. A pulse that stays high for fewer than HW_CYC consecutive synchronised cycles changes nothing: int_rst stays 0 and register 0 keeps its contents.
- R2: A pin that stays high for HW_CYC consecutive synchronised cycles is recognised as a hardware reset. int_rst rises on the next cycle and stays 1 while the synchronised pin stays high.
- R3: Once the synchronised pin has fallen, int_rst stays 1 for STRAP_CYC more cycles. On the last of those cycles strap_in is captured into strap_q. The field layout is [10:6] PHY address, [5:4] auto-negotiation mode, [3:0] bypass options. At all other times strap_q holds its value.
- R4: A write to address 0 with bit 15 set, made while int_rst is 0, starts a software reset. int_rst rises on the next cycle, lasts STRAP_CYC cycles, and ends with a strap capture.
- R5: rd_data[15] reads 1 from the cycle after a software reset starts until int_rst falls. rd_data[14:0] shows the control bits.
- R6: A write to address 0 with bit 15 clear, made while int_rst is 0, stores wr_data[14:0]. Writes to any other address, and any write made while int_rst is 1, are ignored. Every reset restores bits [14:0] to CTRL_DEF.
- R7: busy rises together with a software reset and stays 1 until BUSY_CYC cycles after int_rst falls. A hardware reset alone never raises busy.
- R8: A recognised pin reset that arrives during a software reset or its hold-off window cancels it. rd_data[15] and busy drop on the next cycle, and the sequence restarts from the pin-held phase.
- R9: While int_rst is 1, speed10 is 1 and speed100 is 0. Otherwise speed100 equals control bit 13 and speed10 is its inverse.
- R10: While por_n is low, int_rst is 1, strap_q is 0, rd_data equals CTRL_DEF with bit 15 clear, and busy is 0. After por_n is released, the capture tail of R3 runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| strap_in | input | 11 | Configuration strap inputs |
| int_rst | output | 1 | Internal reset to the PHY core |
| strap_q | output | 11 | Latched strap values |
| rd_data | output | 16 | Read value of control register 0 |
| busy | output | 1 | Software reset and management hold-off in progress |
| speed10 | output | 1 | 10 Mb/s speed indicator |
| speed100 | output | 1 | 100 Mb/s speed indicator |

## Verification
The bench sends a pulse one cycle shorter than the threshold and then one that is long enough. A filter that is off by one would either reset on the short glitch or miss the valid pulse. The strap inputs change during the settling tail and just after it, so a capture that happens on the wrong cycle, or that keeps following the inputs, shows up in strap_q. A pin reset is driven both in the middle of a software reset and during the hold-off window. A design that failed to cancel would leave bit 15 or busy stuck high. Writes made during reset and writes to other addresses are also sent, to catch a register that does not ignore them.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;
   localparam int STRAP_W   = 11;
   localparam int ADDR_W    = 5;
   localparam int REG_W     = 16;
   localparam int RST_BIT   = 15;
   localparam int SPEED_BIT = 13;

   typedef enum logic [1:0] {
      SEQ_RUN   = 2'd0,
      SEQ_HOLD  = 2'd1,
      SEQ_LATCH = 2'd2
   } seq_state_t;

   // ceiling of a/b for cycle conversions
   function automatic int cdiv(input longint a, input longint b);
      return int'((a + b - 1) / b);
   endfunction
endpackage

// File: rtl/phy_rst_pin_filter.sv
module phy_rst_pin_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int HW_CYC      = 25
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_raw,
   output logic pin_s,
   output logic hw_hit
);
   localparam int CNT_W = $clog2(HW_CYC + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (HW_CYC < 2) begin : g_bad_hw
      $error("HW_CYC must be at least 2");
   end

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      logic stage_q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge por_n)
            if (!por_n) stage_q <= 1'b0;
            else        stage_q <= pin_raw;
      end else begin : g_next
         always_ff @(posedge clk or negedge por_n)
            if (!por_n) stage_q <= 1'b0;
            else        stage_q <= g_sync[g-1].stage_q;
      end
   end

   assign pin_s = g_sync[SYNC_STAGES-1].stage_q;

   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                    run_q <= '0;
      else if (!pin_s)               run_q <= '0;
      else if (run_q != CNT_W'(HW_CYC)) run_q <= run_q + 1'b1;
   end

   assign hw_hit = pin_s && (run_q == CNT_W'(HW_CYC - 1));

   // a recognised pulse needs the pin high on the previous cycle too
   p_hit_needs_run_r1: assert property (@(posedge clk) disable iff (!por_n)
      hw_hit |-> $past(pin_s));
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
   import phy_rst_pkg::*;
#(
   parameter int STRAP_CYC = 50,
   parameter int BUSY_CYC  = 12500
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               pin_s,
   input  logic               hw_hit,
   input  logic               sw_req,
   input  logic [STRAP_W-1:0] strap_in,
   output logic               int_rst,
   output logic [STRAP_W-1:0] strap_q,
   output logic               sw_flag,
   output logic               busy
);
   localparam int DLY_W  = $clog2(STRAP_CYC);
   localparam int HOLD_W = $clog2(BUSY_CYC + 1);

   if (STRAP_CYC < 2) begin : g_bad_strap
      $error("STRAP_CYC must be at least 2");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("BUSY_CYC must be at least 1");
   end

   seq_state_t        state_q;
   logic [DLY_W-1:0]  dly_q;
   logic [HOLD_W-1:0] hold_q;
   logic              latch_now;
   logic              sw_start;

   assign latch_now = (state_q == SEQ_LATCH) && (dly_q == DLY_W'(STRAP_CYC - 1)) && !hw_hit;
   assign sw_start  = (state_q == SEQ_RUN) && sw_req && !hw_hit;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= SEQ_LATCH;
         dly_q   <= '0;
         sw_flag <= 1'b0;
         hold_q  <= '0;
         strap_q <= '0;
      end else if (hw_hit) begin
         state_q <= SEQ_HOLD;
         dly_q   <= '0;
         sw_flag <= 1'b0;
         hold_q  <= '0;
      end else begin
         if (hold_q != '0) hold_q <= hold_q - 1'b1;
         unique case (state_q)
            SEQ_RUN: if (sw_start) begin
               state_q <= SEQ_LATCH;
               dly_q   <= '0;
               sw_flag <= 1'b1;
            end
            SEQ_HOLD: if (!pin_s) begin
               state_q <= SEQ_LATCH;
               dly_q   <= '0;
            end
            SEQ_LATCH: if (latch_now) begin
               strap_q <= strap_in;
               state_q <= SEQ_RUN;
               sw_flag <= 1'b0;
               if (sw_flag) hold_q <= HOLD_W'(BUSY_CYC);
            end else begin
               dly_q <= dly_q + 1'b1;
            end
            default: state_q <= SEQ_RUN;
         endcase
      end
   end

   assign int_rst = !por_n || (state_q != SEQ_RUN);
   assign busy    = sw_flag || (hold_q != '0);

   p_rst_after_hit_r2: assert property (@(posedge clk) disable iff (!por_n)
      hw_hit |=> int_rst);
   p_strap_stable_r3: assert property (@(posedge clk) disable iff (!por_n)
      !latch_now |=> $stable(strap_q));
   p_sw_start_r4: assert property (@(posedge clk) disable iff (!por_n)
      sw_start |=> (int_rst && sw_flag));
   p_cancel_r8: assert property (@(posedge clk) disable iff (!por_n)
      hw_hit |=> !busy);
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
   import phy_rst_pkg::*;
#(
   parameter logic [REG_W-1:0] CTRL_DEF = 16'h3000
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              in_rst,
   input  logic              sw_flag,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   output logic              speed10,
   output logic              speed100
);
   logic [REG_W-2:0] ctrl_q;
   logic             wr_hit;

   assign wr_hit = wr_en && (wr_addr == '0) && !wr_data[RST_BIT] && !in_rst;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      ctrl_q <= CTRL_DEF[REG_W-2:0];
      else if (in_rst) ctrl_q <= CTRL_DEF[REG_W-2:0];
      else if (wr_hit) ctrl_q <= wr_data[REG_W-2:0];
   end

   assign rd_data  = {sw_flag, ctrl_q};
   assign speed100 = !in_rst && ctrl_q[SPEED_BIT];
   assign speed10  = in_rst || !ctrl_q[SPEED_BIT];

   p_default_r6: assert property (@(posedge clk) disable iff (!por_n)
      in_rst |=> (rd_data[REG_W-2:0] == CTRL_DEF[REG_W-2:0]));
endmodule

// File: rtl/phy_rst_ctrl.sv
module phy_rst_ctrl
   import phy_rst_pkg::*;
#(
   parameter int               CLK_KHZ     = 25000,
   parameter int               HW_MIN_NS   = 1000,
   parameter int               STRAP_NS    = 2000,
   parameter int               HOLDOFF_US  = 500,
   parameter int               SYNC_STAGES = 2,
   parameter logic [15:0]      CTRL_DEF    = 16'h3000
) (
   input  logic        clk,
   input  logic        por_n,
   input  logic        rst_pin,
   input  logic        wr_en,
   input  logic [4:0]  wr_addr,
   input  logic [15:0] wr_data,
   input  logic [10:0] strap_in,
   output logic        int_rst,
   output logic [10:0] strap_q,
   output logic [15:0] rd_data,
   output logic        busy,
   output logic        speed10,
   output logic        speed100
);
   localparam int HW_CYC    = cdiv(longint'(CLK_KHZ) * HW_MIN_NS, 1000000);
   localparam int STRAP_CYC = cdiv(longint'(CLK_KHZ) * STRAP_NS, 1000000);
   localparam int BUSY_CYC  = cdiv(longint'(CLK_KHZ) * HOLDOFF_US, 1000);

   logic pin_s, hw_hit, sw_flag, sw_req;

   assign sw_req = wr_en && (wr_addr == '0) && wr_data[RST_BIT];

   phy_rst_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .HW_CYC(HW_CYC)) filt_i (
      .clk(clk), .por_n(por_n), .pin_raw(rst_pin), .pin_s(pin_s), .hw_hit(hw_hit));

   phy_rst_seq #(.STRAP_CYC(STRAP_CYC), .BUSY_CYC(BUSY_CYC)) seq_i (
      .clk(clk), .por_n(por_n), .pin_s(pin_s), .hw_hit(hw_hit), .sw_req(sw_req),
      .strap_in(strap_in), .int_rst(int_rst), .strap_q(strap_q),
      .sw_flag(sw_flag), .busy(busy));

   phy_ctrl_reg #(.CTRL_DEF(CTRL_DEF)) reg_i (
      .clk(clk), .por_n(por_n), .in_rst(int_rst), .sw_flag(sw_flag),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_data(rd_data), .speed10(speed10), .speed100(speed100));

   p_speed_r9: assert property (@(posedge clk) disable iff (!por_n)
      int_rst |-> (speed10 && !speed100));
endmodule

// File: tb/phy_rst_ctrl_tb.sv
module phy_rst_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HWC  = 10;    // 10 MHz: 1 us
   localparam int STC  = 20;    // 2 us
   localparam int BSY  = 5000;  // 500 us
   localparam logic [15:0] DEF = 16'h3000;

   logic clk = 1'b0;
   logic por_n = 1'b0, rst_pin = 1'b0, wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [10:0] strap_in = 11'h000;
   logic int_rst, busy, speed10, speed100;
   logic [10:0] strap_q;
   logic [15:0] rd_data;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_rst_ctrl #(.CLK_KHZ(10000)) dut_i (
      .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .strap_in(strap_in), .int_rst(int_rst), .strap_q(strap_q),
      .rd_data(rd_data), .busy(busy), .speed10(speed10), .speed100(speed100));

   // behavioural reference: phase 0 normal, 1 pin held, 2 settling tail
   int m_ph, m_dly, m_hold, m_run;
   bit m_p1, m_p2, m_swf;
   logic [14:0] m_ctrl;
   logic [10:0] m_strap;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_ph = 2; m_dly = 0; m_hold = 0; m_run = 0; m_p1 = 0; m_p2 = 0;
         m_swf = 0; m_ctrl = DEF[14:0]; m_strap = '0;
      end else begin
         bit hit;
         hit = m_p2 && (m_run == HWC - 1);
         if (m_ph != 0) m_ctrl = DEF[14:0];
         else if (wr_en && wr_addr == 0 && !wr_data[15]) m_ctrl = wr_data[14:0];
         if (hit) begin
            m_ph = 1; m_dly = 0; m_swf = 0; m_hold = 0;
         end else begin
            if (m_hold > 0) m_hold--;
            if (m_ph == 0) begin
               if (wr_en && wr_addr == 0 && wr_data[15]) begin m_ph = 2; m_dly = 0; m_swf = 1; end
            end else if (m_ph == 1) begin
               if (!m_p2) begin m_ph = 2; m_dly = 0; end
            end else if (m_dly == STC - 1) begin
               m_strap = strap_in; m_ph = 0;
               if (m_swf) m_hold = BSY;
               m_swf = 0;
            end else m_dly++;
         end
         if (m_p2) m_run = (m_run < HWC) ? m_run + 1 : HWC; else m_run = 0;
         m_p2 = m_p1; m_p1 = rst_pin;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // per-cycle comparison, sampled at the falling edge
   always @(negedge clk) begin
      cyc++;
      if (por_n && !done) begin
         bit mr;
         mr = (m_ph != 0);
         chk("R2", "int_rst", int_rst, mr);
         chk("R3", "strap_q", strap_q, m_strap);
         chk("R5", "rd_data", rd_data, {m_swf, m_ctrl});
         chk("R7", "busy", busy, m_swf || m_hold != 0);
         chk("R9", "speed100", speed100, !mr && m_ctrl[13]);
         chk("R9", "speed10", speed10, mr || !m_ctrl[13]);
      end
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   task automatic finish_run();
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic pulse(input int n);
      @(negedge clk); rst_pin = 1;
      idle(n);
      rst_pin = 0;
   endtask

   initial begin
      strap_in = 11'h5A3;
      idle(3);
      // R10: power-on state
      chk("R10", "int_rst in por", int_rst, 1);
      chk("R10", "strap_q in por", strap_q, 0);
      chk("R10", "rd_data in por", rd_data, DEF);
      chk("R10", "busy in por", busy, 0);
      por_n = 1;
      idle(STC + 5);
      chk("R10", "strap after por", strap_q, 11'h5A3);
      chk("R3", "int_rst low", int_rst, 0);
      strap_in = 11'h0FF;           // R3: no capture outside a reset
      // R6, R9: store a control value with bit 13 clear
      wr(5'd0, 16'h0140);
      idle(1);
      chk("R6", "ctrl write", rd_data, 16'h0140);
      chk("R9", "speed10 after write", speed10, 1);
      wr(5'd4, 16'h2000);
      idle(1);
      chk("R6", "other address ignored", rd_data, 16'h0140);
      chk("R3", "strap held", strap_q, 11'h5A3);
      // R1: a pulse one cycle short of the threshold
      pulse(HWC - 1);
      idle(10);
      chk("R1", "short pulse int_rst", int_rst, 0);
      chk("R1", "short pulse ctrl kept", rd_data, 16'h0140);
      // R2, R3: valid pin reset, strap changes during the tail
      strap_in = 11'h2C7;
      pulse(HWC + 6);
      chk("R2", "int_rst during pulse", int_rst, 1);
      idle(6);
      strap_in = 11'h31E;
      wr(5'd0, 16'h0000);           // R6: ignored during reset
      idle(STC);
      chk("R3", "strap after hw reset", strap_q, 11'h31E);
      chk("R6", "ctrl default after reset", rd_data, DEF);
      chk("R7", "no busy from hw reset", busy, 0);
      // R4, R5, R7: software reset
      strap_in = 11'h4A5;
      wr(5'd0, 16'h8000);
      chk("R5", "reset bit reads 1", rd_data[15], 1);
      chk("R4", "int_rst on sw reset", int_rst, 1);
      idle(STC + 2);
      chk("R4", "strap after sw reset", strap_q, 11'h4A5);
      chk("R5", "reset bit cleared", rd_data[15], 0);
      chk("R7", "busy during holdoff", busy, 1);
      idle(BSY);
      chk("R7", "busy after holdoff", busy, 0);
      // R8: pin reset in the middle of a software reset
      wr(5'd0, 16'h8000);
      idle(3);
      pulse(HWC + 4);
      chk("R8", "bit15 cancelled", rd_data[15], 0);
      chk("R8", "busy cancelled", busy, 0);
      idle(STC + 5);
      // R8: pin reset during the hold-off window
      wr(5'd0, 16'h8000);
      idle(STC + 100);
      chk("R7", "busy in holdoff", busy, 1);
      pulse(HWC + 4);
      chk("R8", "holdoff cancelled", busy, 0);
      idle(STC + 10);
      finish_run();
   end
endmodule